// File: doc/BRIEF.md
# Dual-Mode Parallel Host Bus Port

This block connects a display controller to an 8-bit microcontroller bus. A strap input picks the host bus style. In the enable style, one pin is an enable strobe and the other is a read/write level. In the split-strobe style, the two pins are separate active-low read and write strobes. A register-select pin chooses between display data and the instruction/status path. The port is active only while both chip-select inputs are in their active state.

The strobes, the chip-select result, the register select and the data bus are brought into the block clock domain through a synchronizer. Edge detection on the synchronized strobes turns every completed access into exactly one single-cycle internal event. A data write becomes a RAM write pulse. An instruction write becomes a pulse toward the instruction decoder, and it also starts a fixed busy window.

Data reads are served from a one-stage holding register. The host sees what the holder already contains. The completed read then refills the holder from the RAM port, which has one cycle of read latency. Because of this, the first data read after the RAM address is set returns stale (dummy) data. A status read returns the busy flag in the top bit.

Top module: `mpu_bus_if`

## Requirements
- R1: With any chip-select combination other than `cs1_n`=0 and `cs2`=1, strobes and register select produce no internal pulse. In that state `db_oe` stays 0 and `db_out` reads 8'h00.
- R2: With `mode68`=1, `strb_a` is the enable strobe and `strb_b` is read/write. An access completes on the falling edge of `strb_a`. If `strb_b`=0 at that edge, the access is a write and the byte on `db_in` at that edge is taken. If `strb_b`=1, the access is a read. `db_oe` is 1 while the chip is selected and `strb_a`=1 and `strb_b`=1.
- R3: With `mode68`=0, `strb_a` is an active-low read strobe and `strb_b` is an active-low write strobe. A write completes on the rising edge of `strb_b` and takes the byte present at that edge. A read completes on the rising edge of `strb_a`. `db_oe` is 1 only while the chip is selected and `strb_a`=0.
- R4: A completed write with `rs`=1 produces one `ram_we` pulse that carries the written byte on `ram_wdata`. The same byte is also loaded into the holder.
- R5: A completed write with `rs`=0 produces one `instr_wr` pulse that carries the written byte on `instr_data`.
- R6: During a read with `rs`=1, `db_out` shows the current holder contents. Completing that read issues one `ram_re` pulse. The holder then loads `ram_rdata` from the cycle after `ram_re`. As a result, the read that follows an address set returns the previous holder value, and the addressed byte appears on the second read.
- R7: During a read with `rs`=0, `db_out` is {busy, 7'b0}. Such a read issues no `ram_re`.
- R8: An `instr_wr` pulse sets busy for `BUSY_CYCLES` cycles. While busy is set, data writes, instruction writes and data reads are dropped and produce no pulse. Status reads are still answered.
- R9: Each completed access produces exactly one single-cycle pulse on its output, never more.
- R10: After reset the holder is 8'h00, busy is 0, and `ram_we`, `ram_re` and `instr_wr` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs1_n | input | 1 | Chip select, active low |
| cs2 | input | 1 | Chip select, active high |
| mode68 | input | 1 | Bus style strap: 1 enable style, 0 split strobes |
| rs | input | 1 | Register select: 1 display data, 0 instruction/status |
| strb_a | input | 1 | Enable strobe (mode68=1) or read strobe, active low (mode68=0) |
| strb_b | input | 1 | Read/write level (mode68=1) or write strobe, active low (mode68=0) |
| db_in | input | 8 | Host data bus, input side |
| db_out | output | 8 | Host data bus, output side |
| db_oe | output | 1 | Output enable for the host data bus |
| ram_we | output | 1 | Display RAM write pulse |
| ram_re | output | 1 | Display RAM read pulse |
| ram_wdata | output | 8 | Display RAM write data |
| ram_rdata | input | 8 | Display RAM read data, valid the cycle after `ram_re` |
| instr_wr | output | 1 | Instruction write pulse |
| instr_data | output | 8 | Instruction byte |

## Verification
A holder that loads at the wrong time shows up at `db_out`. The first data read returns a nonzero value, or the addressed byte arrives one read early or one read late; the host sees this on the next read strobe after the fault. A stuck or short busy counter shows up on the next status read as a wrong top bit. It also shows up as a missing or extra write pulse when an access arrives inside the busy window. Errors in edge detection or chip-select decoding change the count of `ram_we`, `ram_re` and `instr_wr` pulses, and this is visible within a few cycles of the strobe edge.

// File: rtl/mbi_pkg.sv
`timescale 1ns/1ps
package mbi_pkg;
  localparam int BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;

  typedef struct packed {
    logic dwr;
    logic iwr;
    logic drd;
    logic srd;
  } acc_t;

  function automatic logic f_cs_ok(input logic c1n, input logic c2);
    return ~c1n & c2;
  endfunction

  // host bus is driven by the block during a read strobe
  function automatic logic f_read_drive(input logic m68, input logic a, input logic b);
    return m68 ? (a & b) : ~a;
  endfunction

  function automatic byte_t f_status(input logic busy);
    return {busy, {(BYTE_W-1){1'b0}}};
  endfunction

  function automatic logic f_rd_done(input logic m68, input logic a_prv,
                                     input logic a_cur, input logic b_cur);
    return m68 ? (a_prv & ~a_cur & b_cur) : (~a_prv & a_cur);
  endfunction

  function automatic logic f_wr_done(input logic m68, input logic a_prv, input logic a_cur,
                                     input logic b_prv, input logic b_cur);
    return m68 ? (a_prv & ~a_cur & ~b_cur) : (~b_prv & b_cur);
  endfunction
endpackage

// File: rtl/mbi_sync_pipe.sv
`timescale 1ns/1ps
module mbi_sync_pipe #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stg
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[i] <= '0;
        else        stg[i] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[i] <= '0;
        else        stg[i] <= stg[i-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/mbi_access_dec.sv
`timescale 1ns/1ps
module mbi_access_dec
  import mbi_pkg::*;
(
  input  logic mode68,
  input  logic cs_cur,
  input  logic cs_prv,
  input  logic rs_cur,
  input  logic a_cur,
  input  logic a_prv,
  input  logic b_cur,
  input  logic b_prv,
  input  logic busy,
  output acc_t acc
);
  logic sel, rd_w, wr_w;

  always_comb begin
    sel  = cs_cur & cs_prv;
    wr_w = sel & f_wr_done(mode68, a_prv, a_cur, b_prv, b_cur);
    rd_w = sel & f_rd_done(mode68, a_prv, a_cur, b_cur) & ~wr_w;
    acc.dwr = wr_w &  rs_cur & ~busy;
    acc.iwr = wr_w & ~rs_cur & ~busy;
    acc.drd = rd_w &  rs_cur & ~busy;
    acc.srd = rd_w & ~rs_cur;
  end
endmodule

// File: rtl/mbi_holder.sv
`timescale 1ns/1ps
module mbi_holder
  import mbi_pkg::*;
#(
  parameter int BUSY_CYCLES = 24
) (
  input  logic  clk,
  input  logic  rst_n,
  input  acc_t  acc,
  input  byte_t wbyte,
  input  byte_t ram_rdata,
  output logic  ram_we,
  output logic  ram_re,
  output byte_t ram_wdata,
  output logic  instr_wr,
  output byte_t instr_data,
  output byte_t holder,
  output logic  busy
);
  localparam int CW = $clog2(BUSY_CYCLES + 1);

  logic [CW-1:0] busy_cnt;
  logic          ld_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ram_we     <= 1'b0;
      ram_re     <= 1'b0;
      instr_wr   <= 1'b0;
      ram_wdata  <= '0;
      instr_data <= '0;
      ld_pend    <= 1'b0;
      holder     <= '0;
    end else begin
      ram_we   <= acc.dwr;
      ram_re   <= acc.drd;
      instr_wr <= acc.iwr;
      ld_pend  <= ram_re;
      if (acc.dwr) begin
        ram_wdata <= wbyte;
        holder    <= wbyte;
      end else if (ld_pend) begin
        holder <= ram_rdata;
      end
      if (acc.iwr) instr_data <= wbyte;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                busy_cnt <= '0;
    else if (acc.iwr)          busy_cnt <= CW'(BUSY_CYCLES);
    else if (busy_cnt != '0)   busy_cnt <= busy_cnt - 1'b1;
  end
  assign busy = (busy_cnt != '0);

  p_pulse_once_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we || ram_re || instr_wr) |=> !($past(ram_we) && ram_we) && !($past(ram_re) && ram_re)
                                        && !($past(instr_wr) && instr_wr));
  p_busy_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy) |-> !(ram_we || ram_re || instr_wr));
  p_busy_after_instr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    instr_wr |-> busy);
  p_holder_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ram_re |-> ##2 (holder == $past(ram_rdata)));
  p_status_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    acc.srd |=> !ram_re);
endmodule

// File: rtl/mpu_bus_if.sv
`timescale 1ns/1ps
module mpu_bus_if
  import mbi_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int BUSY_CYCLES = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs1_n,
  input  logic              cs2,
  input  logic              mode68,
  input  logic              rs,
  input  logic              strb_a,
  input  logic              strb_b,
  input  logic [BYTE_W-1:0] db_in,
  output logic [BYTE_W-1:0] db_out,
  output logic              db_oe,
  output logic              ram_we,
  output logic              ram_re,
  output logic [BYTE_W-1:0] ram_wdata,
  input  logic [BYTE_W-1:0] ram_rdata,
  output logic              instr_wr,
  output logic [BYTE_W-1:0] instr_data
);
  localparam int CTL_W = 3;
  localparam int DAT_W = BYTE_W + 1;

  logic             cs_ok;
  logic [CTL_W-1:0] ctl_cur, ctl_prv;
  logic [DAT_W-1:0] dat_cur;
  acc_t             acc;
  byte_t            holder;
  logic             busy;

  assign cs_ok = f_cs_ok(cs1_n, cs2);

  mbi_sync_pipe #(.W(CTL_W), .STAGES(SYNC_STAGES)) u_ctl_sync (
    .clk(clk), .rst_n(rst_n), .d({cs_ok, strb_a, strb_b}), .q(ctl_cur));

  mbi_sync_pipe #(.W(DAT_W), .STAGES(SYNC_STAGES)) u_dat_sync (
    .clk(clk), .rst_n(rst_n), .d({rs, db_in}), .q(dat_cur));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_prv <= '0;
    else        ctl_prv <= ctl_cur;
  end

  mbi_access_dec u_dec (
    .mode68(mode68),
    .cs_cur(ctl_cur[2]), .cs_prv(ctl_prv[2]),
    .rs_cur(dat_cur[BYTE_W]),
    .a_cur(ctl_cur[1]), .a_prv(ctl_prv[1]),
    .b_cur(ctl_cur[0]), .b_prv(ctl_prv[0]),
    .busy(busy),
    .acc(acc));

  mbi_holder #(.BUSY_CYCLES(BUSY_CYCLES)) u_hold (
    .clk(clk), .rst_n(rst_n), .acc(acc), .wbyte(dat_cur[BYTE_W-1:0]),
    .ram_rdata(ram_rdata), .ram_we(ram_we), .ram_re(ram_re), .ram_wdata(ram_wdata),
    .instr_wr(instr_wr), .instr_data(instr_data), .holder(holder), .busy(busy));

  always_comb begin
    db_oe  = cs_ok & f_read_drive(mode68, strb_a, strb_b);
    db_out = '0;
    if (db_oe) db_out = rs ? holder : f_status(busy);
  end
endmodule

// File: tb/sim_mpu_bus_if.sv
`timescale 1ns/1ps
module sim_mpu_bus_if;
  localparam int BUSY = 24;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, cs1_n, cs2, mode68, rs, strb_a, strb_b;
  logic [7:0] db_in, db_out, ram_wdata, ram_rdata, instr_data;
  logic db_oe, ram_we, ram_re, instr_wr;

  mpu_bus_if #(.SYNC_STAGES(2), .BUSY_CYCLES(BUSY)) u0 (
    .clk(clk), .rst_n(rst_n), .cs1_n(cs1_n), .cs2(cs2), .mode68(mode68), .rs(rs),
    .strb_a(strb_a), .strb_b(strb_b), .db_in(db_in), .db_out(db_out), .db_oe(db_oe),
    .ram_we(ram_we), .ram_re(ram_re), .ram_wdata(ram_wdata), .ram_rdata(ram_rdata),
    .instr_wr(instr_wr), .instr_data(instr_data));

  // RAM model: instruction 8'hBx sets address x; each access advances it
  logic [7:0] mem [16];
  logic [3:0] addr;
  int n_we, n_re, n_iwr;
  logic [7:0] last_w, last_i;
  int n_run, n_fail;
  bit done;

  always @(posedge clk) begin
    if (!rst_n) begin
      addr = '0; ram_rdata <= '0; n_we = 0; n_re = 0; n_iwr = 0;
    end else begin
      if (instr_wr) begin
        n_iwr++; last_i = instr_data;
        if (instr_data[7:4] == 4'hB) addr = instr_data[3:0];
      end
      if (ram_we) begin n_we++; last_w = ram_wdata; mem[addr] = ram_wdata; addr = addr + 1'b1; end
      if (ram_re) begin n_re++; ram_rdata <= mem[addr]; addr = addr + 1'b1; end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic idle_pins();
    strb_a = mode68 ? 1'b0 : 1'b1;
    strb_b = 1'b1;
  endtask

  task automatic set_mode(input logic m);
    cs1_n = 1'b1; cyc(4);
    mode68 = m; idle_pins(); cyc(4);
    cs1_n = 1'b0; cyc(2);
  endtask

  task automatic host_wr(input logic r, input logic [7:0] d);
    rs = r; db_in = d;
    if (mode68) begin
      strb_b = 1'b0; cyc(1); strb_a = 1'b1; cyc(3); strb_a = 1'b0; cyc(4); strb_b = 1'b1;
    end else begin
      strb_b = 1'b0; cyc(3); strb_b = 1'b1; cyc(4);
    end
    cyc(4);
  endtask

  task automatic host_rd(input logic r, output logic [7:0] d, output logic oe);
    rs = r;
    if (mode68) begin
      strb_b = 1'b1; cyc(1); strb_a = 1'b1; cyc(2); d = db_out; oe = db_oe; strb_a = 1'b0;
    end else begin
      strb_a = 1'b0; cyc(2); d = db_out; oe = db_oe; strb_a = 1'b1;
    end
    cyc(7);
  endtask

  task automatic settle(); cyc(BUSY + 8); endtask

  task automatic t_reset();
    chk("R10 db_oe after reset", db_oe, 0);
    chk("R10 ram_we after reset", ram_we, 0);
    chk("R10 ram_re after reset", ram_re, 0);
    chk("R10 instr_wr after reset", instr_wr, 0);
  endtask

  task automatic t_first_read();
    logic [7:0] d; logic oe;
    host_rd(1'b1, d, oe);
    chk("R10 holder clear on first read", d, 8'h00);
    chk("R2 enable-style read drives bus", oe, 1);
    chk("R6 read issues one ram_re", n_re, 1);
    host_rd(1'b0, d, oe);
    chk("R7 idle status", d, 8'h00);
    chk("R7 status read no ram_re", n_re, 1);
  endtask

  task automatic t_instr_busy();
    logic [7:0] d; logic oe; int bi, bw, br;
    bi = n_iwr;
    host_wr(1'b0, 8'hB2);
    chk("R5 instr pulse count", n_iwr, bi + 1);
    chk("R5 instr byte", last_i, 8'hB2);
    br = n_re;
    host_rd(1'b0, d, oe);
    chk("R8 status shows busy", d, 8'h80);
    chk("R7 status read no ram_re", n_re, br);
    bw = n_we;
    host_wr(1'b1, 8'h77);
    chk("R8 data write dropped while busy", n_we, bw);
    settle();
    host_rd(1'b0, d, oe);
    chk("R8 busy cleared", d, 8'h00);
  endtask

  task automatic t_write_6800();
    int bw;
    host_wr(1'b0, 8'hB2); settle();
    bw = n_we;
    host_wr(1'b1, 8'h11); host_wr(1'b1, 8'h22); host_wr(1'b1, 8'h33);
    chk("R9 one ram_we per write", n_we, bw + 3);
    chk("R4 write byte", last_w, 8'h33);
    chk("R2 byte at enable fall stored", mem[3], 8'h22);
  endtask

  task automatic t_read_8080();
    logic [7:0] d; logic oe; int br;
    set_mode(1'b0);
    chk("R3 bus idle with read strobe high", db_oe, 0);
    host_wr(1'b0, 8'hB2); settle();
    br = n_re;
    host_rd(1'b1, d, oe);
    chk("R6 dummy read returns old holder", d, 8'h33);
    chk("R3 split-style read drives bus", oe, 1);
    host_rd(1'b1, d, oe);
    chk("R6 second read returns addressed byte", d, 8'h11);
    host_rd(1'b1, d, oe);
    chk("R6 third read", d, 8'h22);
    chk("R9 one ram_re per read", n_re, br + 3);
  endtask

  task automatic t_write_8080();
    logic [7:0] d; logic oe;
    host_wr(1'b0, 8'hB8); settle();
    host_wr(1'b1, 8'h5A);
    chk("R4 split-style data write", last_w, 8'h5A);
    host_wr(1'b0, 8'hB8); settle();
    host_rd(1'b1, d, oe);
    host_rd(1'b1, d, oe);
    chk("R3 written byte read back", d, 8'h5A);
  endtask

  task automatic t_cs();
    logic [7:0] d; logic oe; int bw, br, bi;
    bw = n_we; br = n_re; bi = n_iwr;
    cs2 = 1'b0; cyc(2);
    host_wr(1'b1, 8'hEE); host_wr(1'b0, 8'hB1);
    host_rd(1'b1, d, oe);
    chk("R1 no drive with cs2 low", oe, 0);
    chk("R1 bus reads zero when deselected", d, 8'h00);
    cs2 = 1'b1; cs1_n = 1'b1; cyc(2);
    host_rd(1'b0, d, oe);
    chk("R1 no drive with cs1_n high", oe, 0);
    host_wr(1'b1, 8'hEF);
    chk("R1 no ram_we while deselected", n_we, bw);
    chk("R1 no ram_re while deselected", n_re, br);
    chk("R1 no instr_wr while deselected", n_iwr, bi);
    cs1_n = 1'b0; cyc(2);
  endtask

  initial begin
    n_run = 0; n_fail = 0; done = 0;
    rst_n = 1'b0; cs1_n = 1'b1; cs2 = 1'b1; mode68 = 1'b1; rs = 1'b0; db_in = '0;
    for (int i = 0; i < 16; i++) mem[i] = '0;
    idle_pins();
    cyc(5);
    rst_n = 1'b1; cyc(2);
    t_reset();
    cs1_n = 1'b0; cyc(4);
    t_first_read();
    t_instr_busy();
    t_write_6800();
    t_read_8080();
    t_write_8080();
    t_cs();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule